// File: doc/BRIEF.md
# Packed Lane Width Converter

This block changes the lane layout of 64-bit packed data. Each operation takes two 64-bit sources. A narrowing operation halves the width of every lane of both sources and clamps each value to the range of the narrower lane, using signed or unsigned saturation. It places the narrowed lanes of the first source in the low half of the result and those of the second source in the high half. A widening operation interleaves lanes. It takes the lanes from the lower 32 bits of both sources, or from the upper 32 bits. Lanes can be bytes, 16-bit words or 32-bit doublewords.

Interleaving with an all-zero second source zero-extends the lanes of the first source. Two rounds of interleaves, first on bytes and then on words, transpose a 4x8 byte matrix into an 8x4 one. The unit accepts one operation per cycle and registers the result. The result stays unchanged until the next accepted operation.

Top module: `lane_convert_unit`

## Requirements
- R1: While reset is active, and after it is released with no operation, `resValid` is 0 and `result` is all zeros.
- R2: An operation presented with `opValid` high at a rising edge appears on `result`, with `resValid` high, after that edge. `resValid` is high for exactly one cycle per accepted operation.
- R3: While `opValid` is low, `result` keeps its value whatever `opSel`, `srcA` and `srcB` do.
- R4: `opSel` 4'b0000 narrows 16-bit lanes to bytes with signed saturation (range -128..127). Word lane i of `srcA` goes to result byte i (0..3), and word lane i of `srcB` goes to result byte 4+i.
- R5: `opSel` 4'b0001 narrows signed 16-bit lanes to bytes with unsigned saturation: a negative value gives 0 and a value above 255 gives 255. Lane placement is as in R4.
- R6: `opSel` 4'b0010 narrows 32-bit lanes to 16-bit words with signed saturation (range -32768..32767). Doubleword lane i of `srcA` goes to result word i (0..1), and lane i of `srcB` goes to result word 2+i.
- R7: `opSel` 4'b10gg interleaves lanes taken from bits 31:0 of both sources, with gg = 00 for bytes, 01 for words and 10 for doublewords. Lane k of `srcA` goes to result lane 2k and lane k of `srcB` goes to result lane 2k+1.
- R8: `opSel` 4'b11gg interleaves the same way, using bits 63:32 of both sources.
- R9: A low byte interleave with `srcB` all zeros gives the four low bytes of `srcA` zero-extended to 16-bit words.
- R10: Byte-level interleaves followed by word-level interleaves of four 8-byte rows give the transposed 8x4 byte matrix.
- R11: The unused codes 4'b0011, 4'b01xx and 4'b1x11 give an all-zero result, and `resValid` still pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Operation present this cycle |
| opSel | input | 4 | Operation code |
| srcA | input | 64 | First source operand |
| srcB | input | 64 | Second source operand |
| resValid | output | 1 | Result updated at the last edge |
| result | output | 64 | Registered result |

## Verification
Every result is due exactly one rising edge after the edge that samples `opValid`. The bench drives each operation on a falling edge and drops `opValid` at the following falling edge. It reads `result` and `resValid` at that same falling edge, half a cycle after the result register loaded. One falling edge later it checks that `resValid` has dropped and `result` has held. The transpose chain feeds results captured in this way back in as sources, one operation at a time.

// File: rtl/lcu_pkg.sv
package lcu_pkg;

  typedef enum logic [1:0] {
    GRAN_BYTE  = 2'd0,
    GRAN_WORD  = 2'd1,
    GRAN_DWORD = 2'd2,
    GRAN_NONE  = 2'd3
  } gran_e;

  // strobes from control to datapath
  typedef struct packed {
    logic  load;        // capture a new result this edge
    logic  doPack;      // narrowing operation
    logic  satUnsigned; // narrowing clamps to unsigned range
    logic  doUnpack;    // interleave operation
    logic  takeHigh;    // interleave draws from upper halves
    gran_e gran;        // pack: target lane size; unpack: lane size
  } ctrl_t;

  localparam logic [3:0] OP_NARROW_SB = 4'b0000;
  localparam logic [3:0] OP_NARROW_UB = 4'b0001;
  localparam logic [3:0] OP_NARROW_SW = 4'b0010;

endpackage

// File: rtl/lcu_ctrl.sv
module lcu_ctrl
  import lcu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       opValid,
  input  logic [3:0] opSel,
  output ctrl_t      ctl,
  output logic       resValid
);

  logic  isUnpack;
  logic  legal;
  gran_e laneGran;

  always_comb begin
    isUnpack = opSel[3];
    laneGran = gran_e'(opSel[1:0]);
    if (isUnpack) begin
      legal = (opSel[1:0] != 2'b11);
    end else begin
      legal = (opSel[2] == 1'b0) && (opSel[1:0] != 2'b11);
    end
  end

  always_comb begin
    ctl             = '0;
    ctl.load        = opValid;
    ctl.doPack      = !isUnpack && legal;
    ctl.doUnpack    = isUnpack && legal;
    ctl.takeHigh    = opSel[2];
    ctl.satUnsigned = (opSel[1:0] == 2'b01);
    if (isUnpack) begin
      ctl.gran = laneGran;
    end else if (opSel[1:0] == 2'b10) begin
      ctl.gran = GRAN_WORD;
    end else begin
      ctl.gran = GRAN_BYTE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resValid <= 1'b0;
    end else begin
      resValid <= opValid;
    end
  end

endmodule

// File: rtl/lcu_datapath.sv
module lcu_datapath
  import lcu_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctl,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] result
);

  localparam int unsigned HALF_W   = DATA_W / 2;
  localparam int unsigned N_BYTES  = DATA_W / 8;
  localparam int unsigned N_WORDS  = DATA_W / 16;
  localparam int unsigned N_GRAN   = 3;

  function automatic logic [7:0] clampS8(input logic signed [15:0] v);
    if (v > 16'sd127)       return 8'h7F;
    else if (v < -16'sd128) return 8'h80;
    else                    return v[7:0];
  endfunction

  function automatic logic [7:0] clampU8(input logic signed [15:0] v);
    if (v < 16'sd0)         return 8'h00;
    else if (v > 16'sd255)  return 8'hFF;
    else                    return v[7:0];
  endfunction

  function automatic logic [15:0] clampS16(input logic signed [31:0] v);
    if (v > 32'sd32767)       return 16'h7FFF;
    else if (v < -32'sd32768) return 16'h8000;
    else                      return v[15:0];
  endfunction

  logic [DATA_W-1:0] packSByte;
  logic [DATA_W-1:0] packUByte;
  logic [DATA_W-1:0] packSWord;

  // word lanes to bytes: first source fills the low half
  for (genvar i = 0; i < N_BYTES; i++) begin : g_nb
    logic [15:0] wideLane;
    if (i < N_BYTES / 2) begin : g_lo
      assign wideLane = srcA[16*i +: 16];
    end else begin : g_hi
      assign wideLane = srcB[16*(i - N_BYTES/2) +: 16];
    end
    assign packSByte[8*i +: 8] = clampS8(wideLane);
    assign packUByte[8*i +: 8] = clampU8(wideLane);
  end

  // doubleword lanes to words
  for (genvar i = 0; i < N_WORDS; i++) begin : g_nw
    logic [31:0] wideLane;
    if (i < N_WORDS / 2) begin : g_lo
      assign wideLane = srcA[32*i +: 32];
    end else begin : g_hi
      assign wideLane = srcB[32*(i - N_WORDS/2) +: 32];
    end
    assign packSWord[16*i +: 16] = clampS16(wideLane);
  end

  // interleave of the chosen halves, one variant per lane size
  logic [HALF_W-1:0] halfA;
  logic [HALF_W-1:0] halfB;
  logic [N_GRAN-1:0][DATA_W-1:0] ilv;

  assign halfA = ctl.takeHigh ? srcA[DATA_W-1:HALF_W] : srcA[HALF_W-1:0];
  assign halfB = ctl.takeHigh ? srcB[DATA_W-1:HALF_W] : srcB[HALF_W-1:0];

  for (genvar g = 0; g < N_GRAN; g++) begin : g_gran
    localparam int unsigned LANE_W  = 8 << g;
    localparam int unsigned N_PAIRS = HALF_W / LANE_W;
    for (genvar k = 0; k < N_PAIRS; k++) begin : g_pair
      assign ilv[g][(2*k)*LANE_W   +: LANE_W] = halfA[k*LANE_W +: LANE_W];
      assign ilv[g][(2*k+1)*LANE_W +: LANE_W] = halfB[k*LANE_W +: LANE_W];
    end
  end

  logic [DATA_W-1:0] nextResult;

  always_comb begin
    nextResult = '0;
    if (ctl.doPack) begin
      if (ctl.gran == GRAN_WORD)  nextResult = packSWord;
      else if (ctl.satUnsigned)   nextResult = packUByte;
      else                        nextResult = packSByte;
    end else if (ctl.doUnpack) begin
      case (ctl.gran)
        GRAN_BYTE:  nextResult = ilv[0];
        GRAN_WORD:  nextResult = ilv[1];
        GRAN_DWORD: nextResult = ilv[2];
        default:    nextResult = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
    end else if (ctl.load) begin
      result <= nextResult;
    end
  end

endmodule

// File: rtl/lane_convert_unit.sv
module lane_convert_unit
  import lcu_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opValid,
  input  logic [3:0]        opSel,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic              resValid,
  output logic [DATA_W-1:0] result
);

  ctrl_t ctl;

  lcu_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .opValid  (opValid),
    .opSel    (opSel),
    .ctl      (ctl),
    .resValid (resValid)
  );

  lcu_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .srcA   (srcA),
    .srcB   (srcB),
    .result (result)
  );

endmodule

// File: rtl/lcu_checker.sv
module lcu_checker #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              opValid,
  input logic [3:0]        opSel,
  input logic [DATA_W-1:0] srcA,
  input logic [DATA_W-1:0] srcB,
  input logic              resValid,
  input logic [DATA_W-1:0] result
);

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opValid |=> resValid);

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !opValid |=> !resValid);

  // R3
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !opValid |=> $stable(result));

  // R5
  neg_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && opSel == 4'b0001 && srcA[15]) |=> (result[7:0] == 8'h00));

  // R7
  low_byte_ilv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && opSel == 4'b1000)
      |=> (result[15:0] == {$past(srcB[7:0]), $past(srcA[7:0])}));

  // R11
  unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && (opSel == 4'b0011 || opSel[3:2] == 2'b01 || opSel[1:0] == 2'b11))
      |=> (result == '0));

endmodule

bind lane_convert_unit lcu_checker #(.DATA_W(DATA_W)) i_lcu_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .opValid  (opValid),
  .opSel    (opSel),
  .srcA     (srcA),
  .srcB     (srcB),
  .resValid (resValid),
  .result   (result)
);

// File: tb/test_lane_convert_unit.sv
module test_lane_convert_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opSel = '0;
  logic [63:0] srcA = '0;
  logic [63:0] srcB = '0;
  logic        resValid;
  logic [63:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  lane_convert_unit i_lane_convert_unit (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opSel(opSel),
    .srcA(srcA), .srcB(srcB), .resValid(resValid), .result(result)
  );

  localparam int NV = 13;
  // R4 R5 R6 R7 R8 R9 R11 vectors
  localparam logic [3:0] T_OP [NV] = '{
    4'b0000, 4'b0001, 4'b0010, 4'b1000, 4'b1001, 4'b1010,
    4'b1100, 4'b1101, 4'b1110, 4'b1000, 4'b0011, 4'b0100, 4'b1011 };
  localparam logic [63:0] T_A [NV] = '{
    64'hFFF0_FF00_00FF_0005, 64'hFFF0_FF00_00FF_0005, 64'hFFFF8000_00012345,
    64'h0706050403020100, 64'h0706050403020100, 64'h0706050403020100,
    64'h0706050403020100, 64'h0706050403020100, 64'h0706050403020100,
    64'hAABBCCDD_F1E2D3C4, 64'h1234_5678_9ABC_DEF0, 64'h0706050403020100,
    64'hFFFF_FFFF_FFFF_FFFF };
  localparam logic [63:0] T_B [NV] = '{
    64'hFF7F_FF80_0080_007F, 64'hFF7F_FF80_0080_007F, 64'hFFFEFFFF_00007FFF,
    64'h1716151413121110, 64'h1716151413121110, 64'h1716151413121110,
    64'h1716151413121110, 64'h1716151413121110, 64'h1716151413121110,
    64'h0, 64'h1111_2222_3333_4444, 64'h1716151413121110,
    64'hFFFF_FFFF_FFFF_FFFF };
  localparam logic [63:0] T_EXP [NV] = '{
    64'h80807F7F_F0807F05, 64'h0000807F_0000FF05, 64'h80007FFF_80007FFF,
    64'h13031202_11011000, 64'h1312_0302_1110_0100, 64'h13121110_03020100,
    64'h17071606_15051404, 64'h1716_0706_1514_0504, 64'h17161514_07060504,
    64'h00F100E2_00D300C4, 64'h0, 64'h0, 64'h0 };
  localparam int T_REQ [NV] = '{4, 5, 6, 7, 7, 7, 8, 8, 8, 9, 11, 11, 11};

  task automatic check(input int req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one operation, return the result one edge later (R2)
  task automatic runOp(input logic [3:0] op, input logic [63:0] a,
                       input logic [63:0] b, input int req,
                       output logic [63:0] res);
    logic [63:0] held;
    @(negedge clk);
    opValid = 1'b1; opSel = op; srcA = a; srcB = b;
    @(negedge clk);
    opValid = 1'b0;
    check(2, {63'b0, resValid}, 64'd1);               // R2 valid pulse
    res  = result;
    held = result;
    opSel = ~op; srcA = ~a; srcB = ~b;                // R3 stimulus
    @(negedge clk);
    check(2, {63'b0, resValid}, 64'd0);               // R2 single cycle
    check(3, result, held);                           // R3 hold
    if (req < 0) check(2, 64'd0, 64'd0);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] r;
    logic [63:0] row [4];
    logic [63:0] lo01, lo23, hi01, hi23;
    logic [63:0] outp [4];
    logic [63:0] expRow [4];

    // R1 reset state
    repeat (3) @(negedge clk);
    check(1, {63'b0, resValid}, 64'd0);
    check(1, result, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(1, {63'b0, resValid}, 64'd0);
    check(1, result, 64'd0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      runOp(T_OP[v], T_A[v], T_B[v], T_REQ[v], r);
      check(T_REQ[v], r, T_EXP[v]);
    end

    // R10 transpose of a 4x8 byte matrix, element (i,j) = 8i+j
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 8; j++) row[i][8*j +: 8] = 8'(8*i + j);
    runOp(4'b1000, row[0], row[1], 10, lo01);
    runOp(4'b1000, row[2], row[3], 10, lo23);
    runOp(4'b1100, row[0], row[1], 10, hi01);
    runOp(4'b1100, row[2], row[3], 10, hi23);
    runOp(4'b1001, lo01, lo23, 10, outp[0]);
    runOp(4'b1101, lo01, lo23, 10, outp[1]);
    runOp(4'b1001, hi01, hi23, 10, outp[2]);
    runOp(4'b1101, hi01, hi23, 10, outp[3]);
    for (int p = 0; p < 4; p++) begin
      expRow[p] = '0;
      for (int h = 0; h < 2; h++)
        for (int k = 0; k < 4; k++)
          expRow[p][32*h + 8*k +: 8] = 8'(8*k + 2*p + h);
      check(10, outp[p], expRow[p]);  // R10
    end

    // R4 boundary values exactly at the limits
    runOp(4'b0000, 64'hFF80_007F_FF81_007E, 64'h0, 4, r);
    check(4, r, 64'h00000000_807F817E);
    // R5 boundary: 255 and 256 and 0
    runOp(4'b0001, 64'h0000_0100_00FF_8000, 64'h0, 5, r);
    check(5, r, 64'h00000000_00FF_FF00);

    // R1 reset in mid-run clears the result
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(1, result, 64'd0);
    check(1, {63'b0, resValid}, 64'd0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule